// File: doc/BRIEF.md
# Transmit Jabber Watchdog Controller

This block sits between a MAC-side controller and a line driver. It passes the controller's transmit-enable request through to the driver. It also times how long each continuous transmission lasts. If a single burst runs past a trip limit, the block treats the controller as stuck. It then shuts the driver off for a fixed penalty time and raises a status flag.

When the penalty time ends, the driver is not handed back straight away. The controller must also have dropped its request. A controller that is still stuck therefore stays locked out, and a recovered one resumes as soon as the penalty ends. A prescaler divides the system clock into millisecond ticks. The defaults are a 25 ms trip limit and a 600 ms penalty. A reduced divider is used for simulation.

Top module: `tx_jabber_guard`

## Requirements
- R1: While reset is asserted, and until the internal reset release completes, the block is in the open state. The jabber flag is 0, all counters are cleared, and with the request low the driver enable is 0. An asynchronous reset during a penalty clears the flag at once.
- R2: In the open state, the driver enable equals the transmit request in the same cycle, with no added latency.
- R3: The millisecond tick fires once every CLK_PER_TICK clocks. The burst counter counts ticks only while the request is high, and it returns to zero whenever the request is low. Bursts that are separated by even one low cycle never add up to a trip.
- R4: A burst trips the guard only after its count has reached TRIP_TICKS ticks. The jabber flag then rises between TRIP_TICKS-1 and TRIP_TICKS+1 tick periods after the request rises.
- R5: From the cycle after a trip, the driver enable is 0 whatever the request does. The penalty lasts HOLD_TICKS ticks, counted from the trip.
- R6: If the request is still high when the penalty ends, the block keeps the driver off and the flag high until the request goes low. It then returns to the open state on the next clock.
- R7: If the request is already low when the penalty ends, the block returns directly to the open state, and the flag falls on the next clock.
- R8: The jabber flag is 1 exactly while the block is in the penalty or in the wait-for-release state.
- R9: Toggling the request during the penalty neither shortens nor lengthens it, and never reaches the driver.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tx_en | input | 1 | Transmit request from the controller |
| drv_en | output | 1 | Gated enable to the line driver |
| jabber | output | 1 | High while the transmit lockout is in force |

## Verification
The bench targets the following corner cases:
- A pair of near-limit bursts split by a single low cycle. A counter that failed to clear would trip here when it should not.
- A request held high straight through the penalty end. A guard acting as a plain timeout would release the driver early in this case.
- A request dropped early in the penalty. A design that always waited for a fresh low edge, or that reset the timer on request changes, would show a wrong flag length.
- Request toggling during the penalty, and an asynchronous reset in mid-penalty. These show whether input activity leaks to the driver or the lockout survives reset.

// File: rtl/jab_pkg.sv
package jab_pkg;
  typedef enum logic [1:0] {
    LK_OPEN       = 2'd0,
    LK_PENALTY    = 2'd1,
    LK_AWAIT_DROP = 2'd2
  } lock_state_t;
endpackage

// File: rtl/jab_tick_gen.sv
module jab_tick_gen #(
  parameter int unsigned DIV = 200000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R3
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/jab_burst_timer.sv
module jab_burst_timer #(
  parameter int unsigned LIMIT = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic armed,
  input  logic tick,
  output logic over_limit
);
  localparam int unsigned RW = $clog2(LIMIT + 1);
  localparam logic [RW-1:0] TOP = RW'(LIMIT);

  logic [RW-1:0] run_q, run_d;

  always_comb begin
    if (!tx_en || !armed)        run_d = '0;
    else if (tick && run_q != TOP) run_d = run_q + RW'(1);
    else                         run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign over_limit = armed && tx_en && (run_q == TOP);

  // R3
  burst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (run_q == '0));

  // R4
  burst_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= TOP);
endmodule

// File: rtl/jab_penalty_timer.sv
module jab_penalty_timer #(
  parameter int unsigned HOLD = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic tick,
  output logic done
);
  localparam int unsigned HW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [HW-1:0] LAST = HW'(HOLD - 1);

  logic [HW-1:0] hold_q, hold_d;

  assign done = active && tick && (hold_q == LAST);

  always_comb begin
    if (start)               hold_d = '0;
    else if (active && tick) hold_d = (hold_q == LAST) ? '0 : hold_q + HW'(1);
    else                     hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  // R5
  hold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= LAST);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> $stable(hold_q));
endmodule

// File: rtl/jab_lock_fsm.sv
module jab_lock_fsm
  import jab_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic        over_limit,
  input  logic        hold_done,
  output lock_state_t state
);
  lock_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      LK_OPEN:       if (over_limit) state_d = LK_PENALTY;
      LK_PENALTY:    if (hold_done)  state_d = tx_en ? LK_AWAIT_DROP : LK_OPEN;
      LK_AWAIT_DROP: if (!tx_en)     state_d = LK_OPEN;
      default:                       state_d = LK_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_OPEN;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R8
  trip_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_OPEN && over_limit) |=> (state_q == LK_PENALTY));

  // R5
  penalty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_PENALTY && !hold_done) |=> (state_q == LK_PENALTY));

  // R6
  await_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_AWAIT_DROP && tx_en) |=> (state_q == LK_AWAIT_DROP));

  // R7
  expire_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_PENALTY && hold_done && !tx_en) |=> (state_q == LK_OPEN));
endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard
  import jab_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK = 200000,
  parameter int unsigned TRIP_TICKS   = 25,
  parameter int unsigned HOLD_TICKS   = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  output logic drv_en,
  output logic jabber
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic        tick;
  logic        over_limit;
  logic        hold_done;
  lock_state_t state;
  logic        is_open;
  logic        in_penalty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign is_open    = (state == LK_OPEN);
  assign in_penalty = (state == LK_PENALTY);

  jab_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick)
  );

  jab_burst_timer #(.LIMIT(TRIP_TICKS)) u_burst (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tx_en      (tx_en),
    .armed      (is_open),
    .tick       (tick),
    .over_limit (over_limit)
  );

  jab_penalty_timer #(.HOLD(HOLD_TICKS)) u_hold (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (over_limit),
    .active (in_penalty),
    .tick   (tick),
    .done   (hold_done)
  );

  jab_lock_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tx_en      (tx_en),
    .over_limit (over_limit),
    .hold_done  (hold_done),
    .state      (state)
  );

  assign drv_en = tx_en && is_open;
  assign jabber = !is_open;
endmodule

// File: tb/tx_jabber_guard_bench.sv
module tx_jabber_guard_bench;
  localparam int DIV  = 4;
  localparam int TRIP = 25;
  localparam int HOLD = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic drv_en, jabber;

  int checks = 0;
  int failures = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tx_jabber_guard #(.CLK_PER_TICK(DIV), .TRIP_TICKS(TRIP), .HOLD_TICKS(HOLD))
    u_tx_jabber_guard (.clk(clk), .rst_n(rst_n), .tx_en(tx_en),
                       .drv_en(drv_en), .jabber(jabber));

  // behavioural reference model
  int m_pre, m_run, m_hold, m_st;
  bit m_s1, m_s2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_run = 0; m_hold = 0; m_st = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      if (!m_s2) begin
        m_pre = 0; m_run = 0; m_hold = 0; m_st = 0;
      end else begin
        bit tk;
        tk = (m_pre == DIV - 1);
        m_pre = tk ? 0 : m_pre + 1;
        case (m_st)
          0: begin
            if (tx_en && m_run == TRIP) begin m_st = 1; m_hold = 0; end
            else if (!tx_en) m_run = 0;
            else if (tk && m_run < TRIP) m_run++;
          end
          1: begin
            m_run = 0;
            if (tk) begin
              if (m_hold == HOLD - 1) begin m_hold = 0; m_st = tx_en ? 2 : 0; end
              else m_hold++;
            end
          end
          default: begin
            m_run = 0;
            if (!tx_en) m_st = 0;
          end
        endcase
      end
      m_s2 = m_s1; m_s1 = 1;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare against model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(drv_en == (tx_en && m_st == 0), phase, drv_en, (tx_en && m_st == 0));
      check(jabber == (m_st != 0), phase, jabber, (m_st != 0));
    end
  end

  task automatic set_tx(bit v, int n);
    @(negedge clk); #1 tx_en = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic wait_jabber(bit v, output int cyc);
    cyc = 0;
    while (jabber != v && cyc < 5000) begin @(negedge clk); cyc++; end
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(drv_en == 0 && jabber == 0, "R1", {drv_en, jabber}, 0);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(jabber == 0, "R1", jabber, 0);

    // R2 passthrough with short bursts
    phase = "R2";
    for (int i = 0; i < 5; i++) begin
      set_tx(1, 50); #1 check(drv_en == 1, "R2", drv_en, 1);
      set_tx(0, 10); #1 check(drv_en == 0, "R2", drv_en, 0);
    end

    // R3 near-limit bursts split by one low cycle
    phase = "R3";
    set_tx(1, 90); set_tx(0, 1); set_tx(1, 90);
    #1 check(jabber == 0, "R3", jabber, 0);
    set_tx(0, 5);

    // R4 trip latency, R6 held request through penalty end
    phase = "R4";
    set_tx(1, 1);
    wait_jabber(1, lat);
    lat++;
    check(lat >= (TRIP - 1) * DIV && lat <= (TRIP + 1) * DIV, "R4", lat, TRIP * DIV);
    phase = "R6";
    repeat (HOLD * DIV + 200) @(negedge clk);
    check(jabber == 1 && drv_en == 0, "R6", {jabber, drv_en}, 2);
    set_tx(0, 1);
    @(negedge clk);
    check(jabber == 0, "R6", jabber, 0);
    set_tx(0, 5);

    // R7 request dropped early, R5 penalty length, R8 flag span
    phase = "R7";
    set_tx(1, 1);
    wait_jabber(1, lat);
    set_tx(0, 10);
    wait_jabber(0, lat);
    lat += 10;
    check(lat >= (HOLD - 1) * DIV && lat <= (HOLD + 1) * DIV, "R5", lat, HOLD * DIV);
    check(jabber == 0, "R8", jabber, 0);
    set_tx(1, 3); #1 check(drv_en == 1, "R2", drv_en, 1);
    set_tx(0, 5);

    // R9 toggling during penalty never reaches the driver
    phase = "R9";
    set_tx(1, 1);
    wait_jabber(1, lat);
    for (int k = 0; k < 200; k++) begin
      set_tx(k[0], 7);
      #1 check(drv_en == 0, "R9", drv_en, 0);
    end
    set_tx(0, 1);
    wait_jabber(0, lat);
    check(jabber == 0, "R9", jabber, 0);

    // R1 asynchronous reset in mid-penalty
    phase = "R1";
    set_tx(1, 1);
    wait_jabber(1, lat);
    set_tx(0, 20);
    #1 rst_n = 1'b0;
    #1 check(jabber == 0 && drv_en == 0, "R1", {jabber, drv_en}, 0);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(jabber == 0, "R1", jabber, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired phase=%s", phase);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule